// File: doc/BRIEF.md
# Windowed Register File

This block holds the integer registers of a processor that uses rotating register windows. Software sees 32 architectural registers. Registers 0 to 7 are globals held in one shared bank, and register 0 always reads as zero. Registers 8 to 15 are the current window's outs, 16 to 23 its locals and 24 to 31 its ins. The physical store holds 8 globals plus 16 registers for each of `NWIN` windows. The outs of window w are the same physical registers as the ins of window w+1 (modulo `NWIN`), so the values a caller leaves in its outs are the callee's ins, and nothing is copied.

A save request moves the window pointer forward and a restore request moves it back. Three counters track how many windows may still be saved into, how many can be restored, and how many are clean. A request that the counters do not allow leaves all state alone and raises a one-cycle trap pulse: spill, clean-window or fill. A return whose delay slot faulted asserts `restore_kill` together with its restore request, and the restore is then dropped. The two read ports are combinational and use the mapping of the current window. The write port takes effect at the clock edge and uses the mapping that holds after any window change in that cycle, so the result of a save can be written to the new window in the same cycle that its operand is read from the old one. `rst_n` is asserted asynchronously and must be released in step with `clk`.

Top module: `wrf_ctrl`

## Requirements
- R1: After reset the window pointer is `CWP_RST` (default 0), cansave is `CANSAVE_RST` (default NWIN-2), canrestore is 0, cleanwin is `CLEAN_RST` (default NWIN-1), no trap output is high, and every register reads zero.
- R2: Register index 0 always reads zero, and a write to it has no effect.
- R3: Index bits [4:3] select the group: 0 for globals, 1 for outs, 2 for locals, 3 for ins, with bits [2:0] selecting the register within the group. Globals are the same in every window. A write appears on the read ports from the next cycle. A read in the write cycle returns the old value.
- R4: A save with cansave not 0 and cleanwin not equal to canrestore advances the pointer by one modulo NWIN, lowers cansave by 1 and raises canrestore by 1. Afterwards the caller's outs read as the ins, and the locals are the ones last stored in that window.
- R5: A save with cansave equal to 0 leaves pointer and counters unchanged and drives `spill_trap` high for exactly the next cycle.
- R6: A save with cansave not 0 and cleanwin equal to canrestore leaves all state unchanged and drives `cleanwin_trap` high for exactly the next cycle. When cansave is also 0, only `spill_trap` is raised.
- R7: A restore with canrestore not 0 moves the pointer back by one, from 0 to NWIN-1. It raises cansave by 1 and lowers canrestore by 1. Afterwards the former ins read as outs, and the restored window's ins and locals read as before its save.
- R8: A restore with canrestore equal to 0 leaves all state unchanged and drives `fill_trap` high for exactly the next cycle.
- R9: A restore request with `restore_kill` high changes no state and raises no trap.
- R10: In a cycle with a successful save or restore, the read ports use the old window and the write port uses the new window.
- R11: When save and restore are requested in the same cycle, the save is performed and the restore is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rd_a_idx | input | 5 | Architectural index, read port A |
| rd_a_val | output | DW | Read data, port A |
| rd_b_idx | input | 5 | Architectural index, read port B |
| rd_b_val | output | DW | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural index for the write |
| wr_val | input | DW | Write data |
| save_req | input | 1 | Request to move to the next window |
| restore_req | input | 1 | Request to move to the previous window |
| restore_kill | input | 1 | Cancels a restore in the same cycle |
| cwp_o | output | CW | Current window pointer |
| cansave_o | output | CW | Windows still available to save into |
| canrestore_o | output | CW | Windows available to restore |
| cleanwin_o | output | CW | Clean-window count |
| spill_trap | output | 1 | One-cycle pulse after a refused save (no space) |
| fill_trap | output | 1 | One-cycle pulse after a refused restore |
| cleanwin_trap | output | 1 | One-cycle pulse after a save refused for clean-window |

## Verification
Wraparound of the window pointer is the hardest case to reach from the ports. From the default reset state, the pointer minus canrestore stays at zero, so no run of saves and restores can wrap. For the same reason, one configuration cannot raise both a spill and a clean-window trap. The bench therefore runs two instances side by side on the same stimulus. One uses the defaults and reaches the spill trap. The other has five windows and starts at pointer 3 with a low clean count, so it wraps forward on a save, wraps back from 0 on a restore, and hits the clean-window trap. A behavioural model of the per-window ins and locals is compared on every clock, under directed sequences and then a long pseudo-random mix of operations.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  // register group selected by architectural index bits [4:3]
  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;

  typedef struct packed {
    logic spill;
    logic fill;
    logic clean;
  } trap_t;

  localparam int GRP_SIZE   = 8;
  localparam int WIN_STRIDE = 16;

  function automatic reg_grp_e grp_of(input logic [4:0] idx);
    return reg_grp_e'(idx[4:3]);
  endfunction

endpackage

// File: rtl/wrf_map.sv
module wrf_map
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = 3,
  parameter int PW   = 8
) (
  input  logic [CW-1:0] win,
  input  logic [4:0]    idx,
  output logic [PW-1:0] phys
);

  logic [CW-1:0] win_up;
  logic [PW-1:0] base_cur;
  logic [PW-1:0] base_up;
  logic [PW-1:0] ofs;

  always_comb begin
    win_up   = (win == CW'(NWIN - 1)) ? '0 : win + CW'(1);
    base_cur = PW'(GRP_SIZE) + PW'(win) * PW'(WIN_STRIDE);
    base_up  = PW'(GRP_SIZE) + PW'(win_up) * PW'(WIN_STRIDE);
    ofs      = PW'(idx[2:0]);
    case (grp_of(idx))
      GRP_GLOBAL: phys = ofs;
      GRP_OUT:    phys = base_up + ofs;
      GRP_LOCAL:  phys = base_cur + PW'(GRP_SIZE) + ofs;
      GRP_IN:     phys = base_cur + ofs;
      default:    phys = '0;
    endcase
  end

endmodule

// File: rtl/wrf_bank.sv
module wrf_bank #(
  parameter int DW    = 32,
  parameter int NPHYS = 136,
  parameter int PW    = 8,
  parameter int NRD   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [PW-1:0]           wr_phys,
  input  logic [DW-1:0]           wr_val,
  input  logic [NRD-1:0][PW-1:0]  rd_phys,
  output logic [NRD-1:0][DW-1:0]  rd_val
);

  logic [DW-1:0] cell_q [NPHYS];
  logic          wr_take;

  // physical slot 0 is register zero and is never written
  assign wr_take = wr_en && (wr_phys != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NPHYS; e++) cell_q[e] <= '0;
    end else if (wr_take) begin
      cell_q[wr_phys] <= wr_val;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_val[p] = cell_q[rd_phys[p]];
  end

endmodule

// File: rtl/wrf_winctl.sv
module wrf_winctl
  import wrf_pkg::*;
#(
  parameter int NWIN        = 8,
  parameter int CW          = 3,
  parameter int CWP_RST     = 0,
  parameter int CANSAVE_RST = 6,
  parameter int CLEAN_RST   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_req,
  input  logic          restore_req,
  input  logic          restore_kill,
  output logic [CW-1:0] cwp_q,
  output logic [CW-1:0] cwp_nxt,
  output logic [CW-1:0] cansave_q,
  output logic [CW-1:0] canrestore_q,
  output logic [CW-1:0] cleanwin_q,
  output trap_t         trap_q
);

  localparam logic [CW-1:0] LAST_WIN = CW'(NWIN - 1);

  logic [CW-1:0] cansave_d;
  logic [CW-1:0] canrestore_d;
  logic [CW-1:0] cleanwin_d;
  trap_t         trap_d;
  logic          state_en;

  always_comb begin
    cwp_nxt      = cwp_q;
    cansave_d    = cansave_q;
    canrestore_d = canrestore_q;
    cleanwin_d   = cleanwin_q;
    trap_d       = '0;
    state_en     = 1'b0;
    if (save_req) begin
      // save has priority over a restore in the same cycle
      if (cansave_q == '0) begin
        trap_d.spill = 1'b1;
      end else if (cleanwin_q == canrestore_q) begin
        trap_d.clean = 1'b1;
      end else begin
        state_en     = 1'b1;
        cwp_nxt      = (cwp_q == LAST_WIN) ? '0 : cwp_q + CW'(1);
        cansave_d    = cansave_q - CW'(1);
        canrestore_d = canrestore_q + CW'(1);
      end
    end else if (restore_req && !restore_kill) begin
      if (canrestore_q == '0) begin
        trap_d.fill = 1'b1;
      end else begin
        state_en     = 1'b1;
        cwp_nxt      = (cwp_q == '0) ? LAST_WIN : cwp_q - CW'(1);
        cansave_d    = cansave_q + CW'(1);
        canrestore_d = canrestore_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q        <= CW'(CWP_RST);
      cansave_q    <= CW'(CANSAVE_RST);
      canrestore_q <= '0;
      cleanwin_q   <= CW'(CLEAN_RST);
    end else if (state_en) begin
      cwp_q        <= cwp_nxt;
      cansave_q    <= cansave_d;
      canrestore_q <= canrestore_d;
      cleanwin_q   <= cleanwin_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= '0;
    else        trap_q <= trap_d;
  end

  // R5
  spill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q.spill |-> (cwp_q == $past(cwp_q)) && (cansave_q == '0));

  // R6
  clean_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q.clean |-> (cwp_q == $past(cwp_q)) && (cleanwin_q == canrestore_q) && (cansave_q != '0));

  // R8
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q.fill |-> (cwp_q == $past(cwp_q)) && (canrestore_q == '0));

  // R6
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trap_q));

  // R4
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cansave_q) + int'(canrestore_q)) == CANSAVE_RST);

  // R7
  cwp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp_q) < NWIN);

  // R9
  kill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && restore_kill && !save_req) |=> (trap_q == '0) && $stable(cwp_q));

endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter int NWIN        = 8,
  parameter int DW          = 32,
  parameter int CWP_RST     = 0,
  parameter int CANSAVE_RST = NWIN - 2,
  parameter int CLEAN_RST   = NWIN - 1,
  localparam int CW         = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_val,
  input  logic [4:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_val,
  input  logic          wr_en,
  input  logic [4:0]    wr_idx,
  input  logic [DW-1:0] wr_val,
  input  logic          save_req,
  input  logic          restore_req,
  input  logic          restore_kill,
  output logic [CW-1:0] cwp_o,
  output logic [CW-1:0] cansave_o,
  output logic [CW-1:0] canrestore_o,
  output logic [CW-1:0] cleanwin_o,
  output logic          spill_trap,
  output logic          fill_trap,
  output logic          cleanwin_trap
);

  localparam int NPHYS = GRP_SIZE + WIN_STRIDE * NWIN;
  localparam int PW    = $clog2(NPHYS);
  localparam int NRD   = 2;

  logic [CW-1:0]          cwp_q;
  logic [CW-1:0]          cwp_nxt;
  trap_t                  trap_q;
  logic [NRD-1:0][4:0]    rd_idx;
  logic [NRD-1:0][PW-1:0] rd_phys;
  logic [NRD-1:0][DW-1:0] rd_val;
  logic [PW-1:0]          wr_phys;

  wrf_winctl #(
    .NWIN(NWIN), .CW(CW), .CWP_RST(CWP_RST),
    .CANSAVE_RST(CANSAVE_RST), .CLEAN_RST(CLEAN_RST)
  ) u_winctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .save_req     (save_req),
    .restore_req  (restore_req),
    .restore_kill (restore_kill),
    .cwp_q        (cwp_q),
    .cwp_nxt      (cwp_nxt),
    .cansave_q    (cansave_o),
    .canrestore_q (canrestore_o),
    .cleanwin_q   (cleanwin_o),
    .trap_q       (trap_q)
  );

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  // reads see the window in force during this cycle
  for (genvar p = 0; p < NRD; p++) begin : g_rmap
    wrf_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_rmap (
      .win  (cwp_q),
      .idx  (rd_idx[p]),
      .phys (rd_phys[p])
    );
  end

  // the write lands in the window in force after this edge
  wrf_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_wmap (
    .win  (cwp_nxt),
    .idx  (wr_idx),
    .phys (wr_phys)
  );

  wrf_bank #(.DW(DW), .NPHYS(NPHYS), .PW(PW), .NRD(NRD)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_phys (wr_phys),
    .wr_val  (wr_val),
    .rd_phys (rd_phys),
    .rd_val  (rd_val)
  );

  assign rd_a_val      = rd_val[0];
  assign rd_b_val      = rd_val[1];
  assign cwp_o         = cwp_q;
  assign spill_trap    = trap_q.spill;
  assign fill_trap     = trap_q.fill;
  assign cleanwin_trap = trap_q.clean;

  // R2
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_val == '0));

  // R2
  zero_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 5'd0) |-> (rd_b_val == '0));

endmodule

// File: tb/wrf_ctrl_tb.sv
module wrf_ctrl_tb_top;

  logic clk;
  logic rst_n;
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  ra, rb, widx;
  logic [31:0] wval;
  logic        we, sv, rs, kl;

  logic [31:0] ra_v [2];
  logic [31:0] rb_v [2];
  logic [2:0]  cwp_v [2];
  logic [2:0]  cs_v [2];
  logic [2:0]  cr_v [2];
  logic [2:0]  cl_v [2];
  logic        sp_v [2];
  logic        fi_v [2];
  logic        ct_v [2];

  wrf_ctrl #(.NWIN(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ra), .rd_a_val(ra_v[0]), .rd_b_idx(rb), .rd_b_val(rb_v[0]),
    .wr_en(we), .wr_idx(widx), .wr_val(wval),
    .save_req(sv), .restore_req(rs), .restore_kill(kl),
    .cwp_o(cwp_v[0]), .cansave_o(cs_v[0]), .canrestore_o(cr_v[0]), .cleanwin_o(cl_v[0]),
    .spill_trap(sp_v[0]), .fill_trap(fi_v[0]), .cleanwin_trap(ct_v[0])
  );

  wrf_ctrl #(.NWIN(5), .CWP_RST(3), .CANSAVE_RST(3), .CLEAN_RST(2)) dut_c (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ra), .rd_a_val(ra_v[1]), .rd_b_idx(rb), .rd_b_val(rb_v[1]),
    .wr_en(we), .wr_idx(widx), .wr_val(wval),
    .save_req(sv), .restore_req(rs), .restore_kill(kl),
    .cwp_o(cwp_v[1]), .cansave_o(cs_v[1]), .canrestore_o(cr_v[1]), .cleanwin_o(cl_v[1]),
    .spill_trap(sp_v[1]), .fill_trap(fi_v[1]), .cleanwin_trap(ct_v[1])
  );

  // ---------------- behavioural reference ----------------
  int          n_chk = 0;
  int          n_bad = 0;
  string       cur_tag = "";
  int          p_n [2]   = '{8, 5};
  int          p_cwp [2] = '{0, 3};
  int          p_cs [2]  = '{6, 3};
  int          p_cl [2]  = '{7, 2};
  int          m_cwp [2], m_cs [2], m_cr [2], m_cl [2];
  bit          m_sp [2], m_fi [2], m_ct [2];
  string       m_tag [2];
  logic [31:0] m_g [2][8];
  logic [31:0] m_in [2][8][8];
  logic [31:0] m_loc [2][8][8];

  function automatic logic [31:0] mread(int i, logic [4:0] idx);
    int k = int'(idx) % 8;
    if (idx == 0) return 32'h0;
    if (idx < 8)  return m_g[i][k];
    if (idx < 16) return m_in[i][(m_cwp[i] + 1) % p_n[i]][k];
    if (idx < 24) return m_loc[i][m_cwp[i]][k];
    return m_in[i][m_cwp[i]][k];
  endfunction

  task automatic mwrite(int i, logic [4:0] idx, logic [31:0] v);
    int k = int'(idx) % 8;
    if (idx == 0) return;
    if (idx < 8)       m_g[i][k] = v;
    else if (idx < 16) m_in[i][(m_cwp[i] + 1) % p_n[i]][k] = v;
    else if (idx < 24) m_loc[i][m_cwp[i]][k] = v;
    else               m_in[i][m_cwp[i]][k] = v;
  endtask

  task automatic mreset(int i);
    m_cwp[i] = p_cwp[i]; m_cs[i] = p_cs[i]; m_cr[i] = 0; m_cl[i] = p_cl[i];
    m_sp[i] = 0; m_fi[i] = 0; m_ct[i] = 0; m_tag[i] = "R1";
    for (int k = 0; k < 8; k++) begin
      m_g[i][k] = 0;
      for (int w = 0; w < 8; w++) begin m_in[i][w][k] = 0; m_loc[i][w][k] = 0; end
    end
  endtask

  task automatic mstep(int i);
    m_sp[i] = 0; m_fi[i] = 0; m_ct[i] = 0; m_tag[i] = "R3";
    if (sv) begin
      if (m_cs[i] == 0) begin m_sp[i] = 1; m_tag[i] = "R5"; end
      else if (m_cl[i] == m_cr[i]) begin m_ct[i] = 1; m_tag[i] = "R6"; end
      else begin
        m_cwp[i] = (m_cwp[i] + 1) % p_n[i]; m_cs[i]--; m_cr[i]++; m_tag[i] = "R4";
      end
      if (rs) m_tag[i] = "R11";
    end else if (rs) begin
      if (kl) m_tag[i] = "R9";
      else if (m_cr[i] == 0) begin m_fi[i] = 1; m_tag[i] = "R8"; end
      else begin
        m_cwp[i] = (m_cwp[i] == 0) ? p_n[i] - 1 : m_cwp[i] - 1;
        m_cs[i]++; m_cr[i]--; m_tag[i] = "R7";
      end
    end
    if (we) mwrite(i, widx, wval);
  endtask

  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) mreset(i);
      else        mstep(i);
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, string what, int i, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s inst%0d actual=%h expected=%h", tag, what, i, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      string st = (cur_tag != "") ? cur_tag : m_tag[i];
      string ta = (cur_tag != "") ? cur_tag : ((ra == 0) ? "R2" : "R3");
      string tb = (cur_tag != "") ? cur_tag : ((rb == 0) ? "R2" : "R3");
      chk(ta, "rd_a", i, ra_v[i], mread(i, ra));
      chk(tb, "rd_b", i, rb_v[i], mread(i, rb));
      chk(st, "cwp", i, 32'(cwp_v[i]), 32'(m_cwp[i]));
      chk(st, "cansave", i, 32'(cs_v[i]), 32'(m_cs[i]));
      chk(st, "canrestore", i, 32'(cr_v[i]), 32'(m_cr[i]));
      chk("R1", "cleanwin", i, 32'(cl_v[i]), 32'(m_cl[i]));
      chk("R5", "spill", i, 32'(sp_v[i]), 32'(m_sp[i]));
      chk("R8", "fill", i, 32'(fi_v[i]), 32'(m_fi[i]));
      chk("R6", "cleantrap", i, 32'(ct_v[i]), 32'(m_ct[i]));
    end
  endtask

  task automatic step(bit s, bit r, bit k, bit w, logic [4:0] wi, logic [31:0] wv,
                      logic [4:0] a, logic [4:0] b);
    @(negedge clk);
    compare_all();
    sv = s; rs = r; kl = k; we = w; widx = wi; wval = wv; ra = a; rb = b;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    sv = 0; rs = 0; kl = 0; we = 0; widx = 0; wval = 0; ra = 0; rb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    cur_tag = "R1";
    step(0, 0, 0, 0, 0, 0, 5'd1, 5'd17);
    step(0, 0, 0, 0, 0, 0, 5'd9, 5'd30);
    cur_tag = "";

    // R2 write to zero register has no effect
    cur_tag = "R2";
    step(0, 0, 0, 1, 5'd0, 32'hDEADBEEF, 5'd0, 5'd0);
    step(0, 0, 0, 0, 0, 0, 5'd0, 5'd0);
    cur_tag = "";

    // R3 group decode, read during write returns old value
    cur_tag = "R3";
    step(0, 0, 0, 1, 5'd3, 32'h0000_0303, 5'd3, 5'd0);
    step(0, 0, 0, 1, 5'd12, 32'h0000_0C0C, 5'd3, 5'd12);
    step(0, 0, 0, 1, 5'd20, 32'h0000_1414, 5'd12, 5'd20);
    step(0, 0, 0, 1, 5'd27, 32'h0000_1B1B, 5'd20, 5'd27);
    step(0, 0, 0, 0, 0, 0, 5'd27, 5'd3);
    cur_tag = "";

    // R10 save while writing a local of the new window, reading old outs
    cur_tag = "R10";
    step(1, 0, 0, 1, 5'd16, 32'h0000_2222, 5'd12, 5'd28);
    step(0, 0, 0, 0, 0, 0, 5'd28, 5'd16);
    step(0, 0, 0, 0, 0, 0, 5'd3, 5'd20);
    cur_tag = "";

    // R4 saves until refused: spill on the default instance, clean trap on the other
    for (int n = 0; n < 7; n++) begin
      step(1, 0, 0, 1, 5'(8 + n), 32'h100 + 32'(n), 5'(24 + n), 5'(16 + n));
      step(0, 0, 0, 1, 5'(17 + n % 7), 32'h200 + 32'(n), 5'(8 + n), 5'(24));
    end
    step(1, 0, 0, 0, 0, 0, 5'd24, 5'd8);
    step(0, 0, 0, 0, 0, 0, 5'd17, 5'd9);

    // R11 save and restore together
    step(1, 1, 0, 0, 0, 0, 5'd24, 5'd16);
    step(0, 0, 0, 0, 0, 0, 5'd25, 5'd16);

    // R9 killed restore
    step(0, 1, 1, 0, 0, 0, 5'd24, 5'd16);
    step(0, 0, 0, 0, 0, 0, 5'd24, 5'd16);

    // R7 restores back past the start, then R8 fill trap
    for (int n = 0; n < 8; n++) begin
      step(0, 1, 0, 0, 0, 0, 5'(24 + n % 8), 5'(16 + n % 8));
      step(0, 0, 0, 0, 0, 0, 5'(8 + n % 8), 5'(20));
    end
    step(0, 1, 0, 0, 0, 0, 5'd8, 5'd16);
    step(0, 0, 0, 0, 0, 0, 5'd8, 5'd16);

    // long mixed run
    for (int c = 0; c < 6000; c++) begin
      int r = int'($urandom_range(0, 99));
      bit s = (r < 30);
      bit q = (r >= 25 && r < 60);
      bit k = q && ($urandom_range(0, 4) == 0);
      step(s, q, k, ($urandom_range(0, 9) < 6), 5'($urandom_range(0, 31)),
           $urandom(), 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end

endmodule